// File: doc/BRIEF.md
# APB UART register and interrupt controller

This block is the software-facing half of a simple byte-oriented serial port. It sits on an APB bus and holds the configuration word, the status flags, the latched event bits and the baud divisor. It also holds one byte in each direction. An external 8N1 shifter connects to its serial side. The shifter takes transmit bytes through a valid/ready handshake and delivers received bytes with a one-cycle strobe. The block drives the baud divisor, a divisor-valid flag and the enable bits toward that shifter.

There is no queueing. A second byte written before the first one has left replaces it and raises a sticky transmit-overrun flag. A byte received while the previous one is still unread replaces it and raises a sticky receive-overrun flag. Transmit-done and receive-stored are latched as events. The two overrun interrupts are live: each is the sticky flag gated by its enable. Five interrupt lines leave the block: one per source, plus a combined line. A read-only window at the top of the 4 KiB page returns twelve identification bytes set by a parameter.

Top module: `sio_apb_ctrl`

## Requirements
- R1: After reset, every register reads zero and both byte buffers hold zero. `tx_valid`, all interrupt lines and `baud_ok` are low.
- R2: Word offsets are DATA 0x00, FLAGS 0x04, CONFIG 0x08, EVENTS 0x0C and DIVISOR 0x10. CONFIG keeps pwdata[6:0], with bit 0 tx enable, 1 rx enable, 2 tx-done irq enable, 3 rx irq enable, 4 tx-overrun irq enable, 5 rx-overrun irq enable and 6 test (driven on `cfg_test`). DIVISOR keeps pwdata[19:0]. Both read back as stored.
- R3: `baud_ok` is high exactly when DIVISOR is 16 or more. `tx_valid` is high only while tx enable, FLAGS.TXFULL and `baud_ok` are all high. `tx_data` shows the held transmit byte.
- R4: Writing DATA while TXFULL is clear sets TXFULL (FLAGS bit 0). Writing DATA while TXFULL is set sets TXOVERRUN (FLAGS bit 2), and the new byte replaces the held one.
- R5: On an edge with `tx_valid` and `tx_ready` both high, TXFULL clears. On that same edge, EVENTS bit 0 is latched if the tx-done irq enable is set. It is not latched otherwise.
- R6: A receive strobe while rx enable is low changes neither the receive buffer nor any flag or event.
- R7: A receive strobe with rx enable high stores the byte and sets RXFULL (FLAGS bit 1). If RXFULL was already set and no DATA read takes place in that cycle, RXOVERRUN (FLAGS bit 3) is also set. EVENTS bit 1 is latched if the rx irq enable is set.
- R8: Reading DATA returns the receive buffer in bits [7:0] and clears RXFULL.
- R9: EVENTS bits 2 and 3 are never stored. They always equal TXOVERRUN AND the CONFIG bit 4, and RXOVERRUN AND the CONFIG bit 5.
- R10: Writing 1s to FLAGS bits 2 and 3 clears those bits, and FLAGS bits 0 and 1 ignore writes. Writing 1s to EVENTS clears the matching bits, and EVENTS bits 2 and 3 also clear FLAGS bits 2 and 3.
- R11: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow EVENTS bits 0 to 3. `irq_any` is their OR.
- R12: Offsets 0xFD0 to 0xFFC return byte (offset-0xFD0)/4 of `ID_BYTES` in bits [7:0], and writes to them are ignored. Other unmapped offsets read zero and ignore writes. `pready` is always 1 and `pslverr` is always 0.
- R13: When a DATA write meets a completing transmit handshake, the new byte is held with TXFULL set and no overrun. When a DATA read meets an accepted receive strobe, the read returns the old byte and the new byte is stored with RXFULL set and no overrun. When an event is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address within the page |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tx_data | output | 8 | Held transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the offered byte |
| rx_data | input | 8 | Received byte |
| rx_strobe | input | 1 | One-cycle received-byte pulse |
| baud_div | output | 20 | Programmed baud divisor |
| baud_ok | output | 1 | Divisor is valid (16 or more) |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_test | output | 1 | Test bit |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit-overrun interrupt |
| irq_rxovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of all interrupt sources |

## Verification
Two pairs of functions can land on the same clock edge: a bus write to DATA together with the shifter's ready pulse, and a bus read of DATA together with a receive strobe. The bench provokes each pair by raising `tx_ready` or `rx_strobe` in the APB access cycle itself. It then judges the result through FLAGS, EVENTS, `tx_data` and a follow-up DATA read. The expected outcome is no overrun, the new byte held, and the old byte returned by the colliding read. A third collision sets the transmit-done event in the same cycle that an EVENTS write clears it, and the bench expects the event to survive.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Word indexes (byte offset / 4) of the register page
  localparam int unsigned WIDX_DATA  = 0;
  localparam int unsigned WIDX_FLAGS = 1;
  localparam int unsigned WIDX_CFG   = 2;
  localparam int unsigned WIDX_EVT   = 3;
  localparam int unsigned WIDX_DIV   = 4;
  localparam int unsigned WIDX_ID_LO = 32'hFD0 >> 2;
  localparam int unsigned WIDX_ID_HI = 32'hFFC >> 2;
  localparam int unsigned ID_N       = WIDX_ID_HI - WIDX_ID_LO + 1;

  localparam int unsigned CFG_W  = 7;
  localparam int unsigned FLAG_W = 4;

  // Configuration word, bit 0 is the LSB (tx_en)
  typedef struct packed {
    logic test;
    logic rxo_ie;
    logic txo_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } cfg_t;

  // Status flags, bit 0 is tx_full
  typedef struct packed {
    logic rx_ovr;
    logic tx_ovr;
    logic rx_full;
    logic tx_full;
  } flags_t;

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sio_apb_if.sv
module sio_apb_if
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DIV_W    = 20,
  parameter int unsigned DW       = 8,
  parameter logic [8*ID_N-1:0] ID_BYTES = '0
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     rx_buf,
  input  flags_t            flags,
  input  cfg_t              cfg,
  input  logic [FLAG_W-1:0] evts,
  input  logic [DIV_W-1:0]  div,
  output logic              wr_data,
  output logic              wr_flags,
  output logic              wr_cfg,
  output logic              wr_evt,
  output logic              wr_div,
  output logic              rd_data,
  output logic [31:0]       prdata
);

  localparam int unsigned IW    = ADDR_W - 2;
  localparam int unsigned ID_IW = $clog2(ID_N);

  logic [IW-1:0]    word_idx;
  logic             in_id;
  logic [ID_IW-1:0] id_off;
  logic             acc_wr;
  logic             acc_rd;
  logic [7:0]       id_arr [ID_N];
  logic             unused_lsb;

  assign word_idx   = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign in_id      = (word_idx >= IW'(WIDX_ID_LO)) && (word_idx <= IW'(WIDX_ID_HI));
  assign id_off     = ID_IW'(word_idx - IW'(WIDX_ID_LO));

  for (genvar g = 0; g < ID_N; g++) begin : g_id
    assign id_arr[g] = ID_BYTES[8*g +: 8];
  end

  assign acc_wr = psel && penable && pwrite;
  assign acc_rd = psel && penable && !pwrite;

  assign wr_data  = acc_wr && (word_idx == IW'(WIDX_DATA));
  assign wr_flags = acc_wr && (word_idx == IW'(WIDX_FLAGS));
  assign wr_cfg   = acc_wr && (word_idx == IW'(WIDX_CFG));
  assign wr_evt   = acc_wr && (word_idx == IW'(WIDX_EVT));
  assign wr_div   = acc_wr && (word_idx == IW'(WIDX_DIV));
  assign rd_data  = acc_rd && (word_idx == IW'(WIDX_DATA));

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (word_idx == IW'(WIDX_DATA)) begin
        prdata[DW-1:0] = rx_buf;
      end else if (word_idx == IW'(WIDX_FLAGS)) begin
        prdata[FLAG_W-1:0] = flags;
      end else if (word_idx == IW'(WIDX_CFG)) begin
        prdata[CFG_W-1:0] = cfg;
      end else if (word_idx == IW'(WIDX_EVT)) begin
        prdata[FLAG_W-1:0] = evts;
      end else if (word_idx == IW'(WIDX_DIV)) begin
        prdata[DIV_W-1:0] = div;
      end else if (in_id) begin
        prdata[7:0] = id_arr[id_off];
      end
    end
  end

endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  input  logic          tx_en,
  input  logic          baud_ok,
  input  logic          tx_ready,
  input  logic          clr_ovr,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          full,
  output logic          ovr,
  output logic          sent
);

  logic          full_q, full_d;
  logic          ovr_q, ovr_d;
  logic [DW-1:0] byte_q;

  assign tx_valid = tx_en && full_q && baud_ok;
  assign sent     = tx_valid && tx_ready;

  always_comb begin
    full_d = full_q;
    ovr_d  = ovr_q;
    if (clr_ovr) ovr_d = 1'b0;
    if (sent) full_d = 1'b0;
    if (wr_stb) begin
      if (full_q && !sent) ovr_d = 1'b1;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      if (wr_stb) byte_q <= wdata;
    end
  end

  assign tx_data = byte_q;
  assign full    = full_q;
  assign ovr     = ovr_q;

  a_r4_ovr_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && full && !sent |=> ovr);

  a_r5_sent_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    sent && !wr_stb |=> !full);

  a_r4_write_loads_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> full && (tx_data == $past(wdata)));

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_in,
  input  logic          rx_en,
  input  logic          rd_stb,
  input  logic          clr_ovr,
  output logic [DW-1:0] rx_buf,
  output logic          full,
  output logic          ovr,
  output logic          stored
);

  logic          full_q, full_d;
  logic          ovr_q, ovr_d;
  logic [DW-1:0] byte_q;

  assign stored = rx_strobe && rx_en;

  always_comb begin
    full_d = full_q;
    ovr_d  = ovr_q;
    if (clr_ovr) ovr_d = 1'b0;
    if (rd_stb) full_d = 1'b0;
    if (stored) begin
      if (full_q && !rd_stb) ovr_d = 1'b1;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      if (stored) byte_q <= rx_in;
    end
  end

  assign rx_buf = byte_q;
  assign full   = full_q;
  assign ovr    = ovr_q;

  a_r6_drop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe && !rx_en |=> $stable(rx_buf));

  a_r7_accept_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe && rx_en |=> full && (rx_buf == $past(rx_in)));

  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !rx_strobe |=> !full);

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_sent,
  input  logic       rx_stored,
  input  logic       tx_ie,
  input  logic       rx_ie,
  input  logic       txo_ie,
  input  logic       rxo_ie,
  input  logic       tx_ovr,
  input  logic       rx_ovr,
  input  logic [3:0] clr,
  output logic [3:0] evts,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_txovr,
  output logic       irq_rxovr,
  output logic       irq_any
);

  logic evt_tx_q, evt_tx_d;
  logic evt_rx_q, evt_rx_d;
  logic set_tx, set_rx;

  assign set_tx = tx_sent && tx_ie;
  assign set_rx = rx_stored && rx_ie;

  always_comb begin
    evt_tx_d = evt_tx_q;
    evt_rx_d = evt_rx_q;
    if (clr[0]) evt_tx_d = 1'b0;
    if (clr[1]) evt_rx_d = 1'b0;
    if (set_tx) evt_tx_d = 1'b1;
    if (set_rx) evt_rx_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_tx_q <= 1'b0;
      evt_rx_q <= 1'b0;
    end else begin
      evt_tx_q <= evt_tx_d;
      evt_rx_q <= evt_rx_d;
    end
  end

  assign evts      = {rx_ovr && rxo_ie, tx_ovr && txo_ie, evt_rx_q, evt_tx_q};
  assign irq_tx    = evts[0];
  assign irq_rx    = evts[1];
  assign irq_txovr = evts[2];
  assign irq_rxovr = evts[3];
  assign irq_any   = |evts;

  a_r5_tx_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sent && tx_ie |=> irq_tx);

  a_r10_rx_event_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr[1] && !(rx_stored && rx_ie) |=> !irq_rx);

  a_r5_tx_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx && !clr[0] |=> irq_tx);

endmodule

// File: rtl/sio_apb_ctrl.sv
module sio_apb_ctrl
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DIV_W    = 20,
  parameter int unsigned DIV_MIN  = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned RST_STG  = 2,
  parameter logic [8*ID_N-1:0] ID_BYTES = 96'h5C3A91E7_00024713_00000001
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_strobe,
  output logic [DIV_W-1:0]  baud_div,
  output logic              baud_ok,
  output logic              cfg_tx_en,
  output logic              cfg_rx_en,
  output logic              cfg_test,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);

  logic              rst_n;
  cfg_t              cfg_q, cfg_d;
  logic [DIV_W-1:0]  div_q, div_d;
  flags_t            flags;
  logic [FLAG_W-1:0] evts;
  logic [DW-1:0]     rx_buf;
  logic              wr_data, wr_flags, wr_cfg, wr_evt, wr_div, rd_data;
  logic              clr_txovr, clr_rxovr;
  logic              tx_sent, rx_stored;
  logic              tx_full, tx_ovr, rx_full, rx_ovr;
  logic [3:0]        evt_clr;
  logic              unused_wdata;

  assign unused_wdata = ^pwdata[31:DIV_W];

  sio_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  sio_apb_if #(
    .ADDR_W   (ADDR_W),
    .DIV_W    (DIV_W),
    .DW       (DW),
    .ID_BYTES (ID_BYTES)
  ) u_if (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .rx_buf   (rx_buf),
    .flags    (flags),
    .cfg      (cfg_q),
    .evts     (evts),
    .div      (div_q),
    .wr_data  (wr_data),
    .wr_flags (wr_flags),
    .wr_cfg   (wr_cfg),
    .wr_evt   (wr_evt),
    .wr_div   (wr_div),
    .rd_data  (rd_data),
    .prdata   (prdata)
  );

  // Overrun flags clear from either FLAGS or EVENTS, same bit positions
  assign clr_txovr = (wr_flags || wr_evt) && pwdata[2];
  assign clr_rxovr = (wr_flags || wr_evt) && pwdata[3];
  assign evt_clr   = wr_evt ? pwdata[3:0] : 4'b0000;

  assign baud_ok = (div_q >= DIV_W'(DIV_MIN));

  sio_tx_hold #(.DW(DW)) u_tx (
    .clk      (pclk),
    .rst_n    (rst_n),
    .wr_stb   (wr_data),
    .wdata    (pwdata[DW-1:0]),
    .tx_en    (cfg_q.tx_en),
    .baud_ok  (baud_ok),
    .tx_ready (tx_ready),
    .clr_ovr  (clr_txovr),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .full     (tx_full),
    .ovr      (tx_ovr),
    .sent     (tx_sent)
  );

  sio_rx_hold #(.DW(DW)) u_rx (
    .clk       (pclk),
    .rst_n     (rst_n),
    .rx_strobe (rx_strobe),
    .rx_in     (rx_data),
    .rx_en     (cfg_q.rx_en),
    .rd_stb    (rd_data),
    .clr_ovr   (clr_rxovr),
    .rx_buf    (rx_buf),
    .full      (rx_full),
    .ovr       (rx_ovr),
    .stored    (rx_stored)
  );

  assign flags = '{rx_ovr: rx_ovr, tx_ovr: tx_ovr, rx_full: rx_full, tx_full: tx_full};

  sio_irq_ctrl u_irq (
    .clk       (pclk),
    .rst_n     (rst_n),
    .tx_sent   (tx_sent),
    .rx_stored (rx_stored),
    .tx_ie     (cfg_q.tx_ie),
    .rx_ie     (cfg_q.rx_ie),
    .txo_ie    (cfg_q.txo_ie),
    .rxo_ie    (cfg_q.rxo_ie),
    .tx_ovr    (tx_ovr),
    .rx_ovr    (rx_ovr),
    .clr       (evt_clr),
    .evts      (evts),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .irq_txovr (irq_txovr),
    .irq_rxovr (irq_rxovr),
    .irq_any   (irq_any)
  );

  always_comb begin
    cfg_d = cfg_q;
    div_d = div_q;
    if (wr_cfg) cfg_d = cfg_t'(pwdata[CFG_W-1:0]);
    if (wr_div) div_d = pwdata[DIV_W-1:0];
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_d;
      if (wr_div) div_q <= div_d;
    end
  end

  assign baud_div  = div_q;
  assign cfg_tx_en = cfg_q.tx_en;
  assign cfg_rx_en = cfg_q.rx_en;
  assign cfg_test  = cfg_q.test;
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

  a_r2_cfg_load: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_cfg |=> cfg_q == cfg_t'($past(pwdata[CFG_W-1:0])));

  a_r2_div_load: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_div |=> baud_div == $past(pwdata[DIV_W-1:0]));

  a_r3_offer_stable: assert property (@(posedge pclk) disable iff (!rst_n)
    tx_valid && !tx_ready && !(psel && penable && pwrite) |=> tx_valid && $stable(tx_data));

  a_r13_tx_collide: assert property (@(posedge pclk) disable iff (!rst_n)
    wr_data && tx_valid && tx_ready |=> tx_full && (tx_ovr == $past(tx_ovr)));

endmodule

// File: tb/sio_apb_ctrl_tb_top.sv
module sio_apb_ctrl_tb_top;

  localparam logic [95:0] ID_EXP = 96'h5C3A91E7_00024713_00000001;
  localparam logic [11:0] A_DATA = 12'h000, A_FLAGS = 12'h004, A_CFG = 12'h008,
                          A_EVT = 12'h00C, A_DIV = 12'h010, A_ID = 12'hFD0;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_strobe = 1'b0;
  logic [19:0] baud_div;
  logic        baud_ok, cfg_tx_en, cfg_rx_en, cfg_test;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t rd_q[$];
  exp_t tx_q[$];

  always #5 pclk = ~pclk;

  sio_apb_ctrl #(.ID_BYTES(ID_EXP)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_strobe(rx_strobe), .baud_div(baud_div), .baud_ok(baud_ok),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .cfg_test(cfg_test),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr),
    .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Driver: one APB transfer; optional ready pulse or rx strobe in the access cycle
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag,
                      input bit rdy, input logic [7:0] rdy_exp,
                      input bit rxs, input logic [7:0] rxb);
    exp_t e;
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    if (!wr) begin e.val = exp; e.tag = tag; rd_q.push_back(e); end
    @(negedge pclk);
    penable = 1'b1;
    if (rdy) begin tx_ready = 1'b1; e.val = {24'h0, rdy_exp}; e.tag = tag; tx_q.push_back(e); end
    if (rxs) begin rx_strobe = 1'b1; rx_data = rxb; end
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tx_ready = 1'b0; rx_strobe = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    xfer(1'b1, a, d, '0, "", 1'b0, '0, 1'b0, '0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    xfer(1'b0, a, '0, exp, tag, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic ready_pulse(input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge pclk);
    tx_ready = 1'b1; e.val = {24'h0, exp}; e.tag = tag; tx_q.push_back(e);
    @(negedge pclk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge pclk);
    rx_data = b; rx_strobe = 1'b1;
    @(negedge pclk);
    rx_strobe = 1'b0;
  endtask

  // Monitor: compare reads and transmitted bytes just before the active edge
  initial begin
    exp_t e;
    forever begin
      @(negedge pclk);
      #3;
      if (psel && penable && !pwrite) begin
        n_chk++;
        if (rd_q.size() == 0) begin
          n_fail++; $display("FAIL R12 unexpected read actual=%h expected=none", prdata);
        end else begin
          e = rd_q.pop_front();
          if (prdata !== e.val) begin
            n_fail++; $display("FAIL %s actual=%h expected=%h", e.tag, prdata, e.val);
          end
        end
      end
      if (tx_valid && tx_ready) begin
        n_chk++;
        if (tx_q.size() == 0) begin
          n_fail++; $display("FAIL R3 unexpected send actual=%h expected=none", tx_data);
        end else begin
          e = tx_q.pop_front();
          if ({24'h0, tx_data} !== e.val) begin
            n_fail++; $display("FAIL %s actual=%h expected=%h", e.tag, tx_data, e.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge pclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    // R1 reset state
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    check("R1 irq_any", {31'h0, irq_any}, 32'h0);
    check("R1 baud_ok", {31'h0, baud_ok}, 32'h0);
    check("R1 tx_data", {24'h0, tx_data}, 32'h0);
    rd(A_FLAGS, 32'h0, "R1 flags");
    rd(A_CFG,   32'h0, "R1 cfg");
    rd(A_EVT,   32'h0, "R1 events");
    rd(A_DIV,   32'h0, "R1 divisor");
    rd(A_DATA,  32'h0, "R1 rx buffer");

    // R2 field widths, R3 divisor validity
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, 32'h000F_FFFF, "R2 divisor width");
    check("R3 baud_ok max", {31'h0, baud_ok}, 32'h1);
    wr(A_DIV, 32'd15);
    check("R3 baud_ok 15", {31'h0, baud_ok}, 32'h0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, 32'h7F, "R2 cfg width");
    check("R2 cfg_test", {31'h0, cfg_test}, 32'h1);
    wr(A_CFG, 32'h3F);

    // R3 / R4 transmit offer gated by divisor
    wr(A_DATA, 32'h5A);
    rd(A_FLAGS, 32'h1, "R4 txfull set");
    check("R3 no offer bad divisor", {31'h0, tx_valid}, 32'h0);
    wr(A_DIV, 32'd16);
    check("R3 offer", {31'h0, tx_valid}, 32'h1);
    check("R3 tx_data", {24'h0, tx_data}, 32'h5A);

    // R4 overrun, R9 live overrun irq, R5 send
    wr(A_DATA, 32'h11);
    rd(A_FLAGS, 32'h5, "R4 tx overrun");
    check("R9 irq_txovr", {31'h0, irq_txovr}, 32'h1);
    check("R11 irq_any", {31'h0, irq_any}, 32'h1);
    rd(A_EVT, 32'h4, "R9 events txo");
    ready_pulse(8'h11, "R4 replaced byte");
    rd(A_FLAGS, 32'h4, "R5 txfull cleared");
    rd(A_EVT, 32'h5, "R5 tx event");
    check("R11 irq_tx", {31'h0, irq_tx}, 32'h1);

    // R10 write-one-to-clear
    wr(A_EVT, 32'h4);
    rd(A_FLAGS, 32'h0, "R10 events clears flag");
    rd(A_EVT, 32'h1, "R10 events after clear");
    wr(A_FLAGS, 32'h3);
    rd(A_FLAGS, 32'h0, "R10 flags ro bits");
    wr(A_EVT, 32'h1);
    check("R10 irq_any clear", {31'h0, irq_any}, 32'h0);

    // R7 receive, overrun, R8 read
    rx_send(8'hA5);
    rd(A_FLAGS, 32'h2, "R7 rxfull");
    check("R7 irq_rx", {31'h0, irq_rx}, 32'h1);
    rx_send(8'h3C);
    rd(A_FLAGS, 32'hA, "R7 rx overrun");
    check("R9 irq_rxovr", {31'h0, irq_rxovr}, 32'h1);
    rd(A_DATA, 32'h3C, "R8 data read");
    rd(A_FLAGS, 32'h8, "R8 rxfull cleared");
    wr(A_FLAGS, 32'h8);
    rd(A_FLAGS, 32'h0, "R10 flags w1c");
    check("R9 irq_rxovr cleared", {31'h0, irq_rxovr}, 32'h0);
    rd(A_EVT, 32'h2, "R10 rx event remains");
    wr(A_EVT, 32'h2);

    // R6 receive disabled
    wr(A_CFG, 32'h3D);
    rx_send(8'h77);
    rd(A_FLAGS, 32'h0, "R6 flags untouched");
    rd(A_EVT, 32'h0, "R6 events untouched");
    rd(A_DATA, 32'h3C, "R6 buffer untouched");

    // R9 overrun irq follows its enable live
    wr(A_CFG, 32'h0B);
    rx_send(8'h01);
    rx_send(8'h02);
    rd(A_EVT, 32'h2, "R9 masked rxo");
    check("R9 irq_rxovr masked", {31'h0, irq_rxovr}, 32'h0);
    wr(A_CFG, 32'h2B);
    check("R9 irq_rxovr enable", {31'h0, irq_rxovr}, 32'h1);
    wr(A_EVT, 32'hA);
    rd(A_FLAGS, 32'h2, "R10 events bit3 clears flag");
    check("R11 irq_any after", {31'h0, irq_any}, 32'h0);
    rd(A_DATA, 32'h02, "R8 latest byte");

    // R5 no event when tx irq disabled
    wr(A_CFG, 32'h0B);
    wr(A_DATA, 32'h33);
    ready_pulse(8'h33, "R5 send masked");
    rd(A_EVT, 32'h0, "R5 no tx event");
    rd(A_FLAGS, 32'h0, "R5 flags idle");

    // R13 collisions
    wr(A_CFG, 32'h3F);
    wr(A_DATA, 32'h44);
    xfer(1'b1, A_DATA, 32'h55, '0, "R13 tx collide send", 1'b1, 8'h44, 1'b0, '0);
    rd(A_FLAGS, 32'h1, "R13 tx collide flags");
    rd(A_EVT, 32'h1, "R13 tx collide event");
    check("R13 tx collide byte", {24'h0, tx_data}, 32'h55);
    ready_pulse(8'h55, "R13 second byte");
    wr(A_EVT, 32'h1);
    wr(A_DATA, 32'h66);
    xfer(1'b1, A_EVT, 32'h1, '0, "R13 set wins send", 1'b1, 8'h66, 1'b0, '0);
    rd(A_EVT, 32'h1, "R13 set beats clear");
    wr(A_EVT, 32'h1);
    rx_send(8'h81);
    xfer(1'b0, A_DATA, '0, 32'h81, "R13 rx collide old byte", 1'b0, '0, 1'b1, 8'h92);
    rd(A_FLAGS, 32'h2, "R13 rx collide no overrun");
    rd(A_DATA, 32'h92, "R13 rx collide new byte");
    wr(A_EVT, 32'h2);

    // R12 identification window and unmapped space
    for (int i = 0; i < 12; i++) begin
      rd(A_ID + 12'(4*i), {24'h0, ID_EXP[8*i +: 8]}, "R12 id byte");
    end
    wr(A_ID, 32'hFFFF_FFFF);
    rd(A_ID, {24'h0, ID_EXP[7:0]}, "R12 id read-only");
    rd(12'hFCC, 32'h0, "R12 below window");
    rd(12'h014, 32'h0, "R12 unmapped read");
    wr(12'h014, 32'hFFFF_FFFF);
    rd(A_CFG, 32'h3F, "R12 unmapped write cfg");
    rd(A_FLAGS, 32'h0, "R12 unmapped write flags");
    check("R12 pready", {31'h0, pready}, 32'h1);
    check("R12 pslverr", {31'h0, pslverr}, 32'h0);

    repeat (2) @(negedge pclk);
    check("R12 read queue drained", rd_q.size(), 32'h0);
    check("R3 send queue drained", tx_q.size(), 32'h0);
    finish_run();
  end

endmodule